// File: doc/BRIEF.md
# Host PHY clock-mode configuration sequencer

This block reprograms the control registers of a storage-card host PHY each time software asks for a new bus clock and timing mode. A one-cycle request strobe captures a timing-mode index and a clock-frequency code. The static configuration inputs (output tap, input tap, trim, drive strength, strobe select, clock-buffer select and a poll limit) are assumed to stay stable while the block is busy. The block then issues a fixed series of masked register writes, one per cycle, into its own three-register PHY control file. The current contents of that file drive the PHY through the `ctl_*` outputs, and the write port is visible at the outputs for observation.

Two paths exist. At high clock rates in the faster timing modes, the sequencer locks the PHY DLL and waits for its ready flag, giving up after a programmable number of cycles. In every other case it selects the raw delay chain and loads the input tap. Both successful paths finish with a clock-buffer write and a one-cycle `done` pulse. A DLL that never reports ready produces a one-cycle `err` pulse instead.

Top module: `phy_clkcfg_seq`

## Requirements
- R1: The first write of every accepted request goes to register 0 (DLL register) with mask 0x1 and data 0, which clears the DLL enable bit 0 before any tap, clock or mode change.
- R2: The second write goes to register 1 (tap register). It sets bits [3:0] to the output-tap select, and bit 4 to 1 only when the mode index is above 4, otherwise 0. Mode indices are 0 legacy, 1 card high speed, 2 SD high speed, 3 UHS 12.5 MHz, 4 UHS 25 MHz, 5 UHS 50 MHz, 6 UHS 104 MHz, 7 UHS DDR, 8 card DDR, 9 HS200 and 10 HS400.
- R3: The DLL path runs only when the mode index is above 4 and the frequency code is not 3. Frequency codes are 0 = 200 MHz, 1 = 100 MHz, 2 = another clock of at least 50 MHz, and 3 = below 50 MHz. All other cases run the delay-chain path.
- R4: The DLL path writes, in this order, register 2 (mode register) mask 0x30 data 0, then the frequency select, then register 0 with trim at [7:4] and drive strength at [10:8] (mask 0x7F0), then register 0 mask 0x1 data 1. It then waits for `dll_ready`.
- R5: With the two-bit frequency encoding (FREQ_2BIT=1) the frequency write uses mask 0x300, with bit 8 as the 50 MHz select and bit 9 as the 100 MHz select. Code 0 gives neither bit, code 1 gives bit 9, and any other code gives bit 8. With the three-bit encoding, the write uses mask 0x700 and carries 0 for code 0 and 4 in [10:8] otherwise.
- R6: The delay-chain path writes register 2 mask 0x30 data 0x30, then register 1 mask 0x1F00 with the input tap in [12:8], and leaves the DLL disabled.
- R7: For mode 10 only, the second write also carries the strobe select in bits [27:24] (STRB_4BIT=1) or [31:24] (STRB_4BIT=0), and its mask covers that field.
- R8: Both successful paths end with a write of register 2 mask 0x7 carrying the clock-buffer select. `done` is high for exactly the next cycle.
- R9: `dll_ready` must be seen within `poll_limit` wait cycles; if it is seen in the last permitted cycle, the block succeeds. Otherwise `err` pulses for one cycle, no clock-buffer write is made, and the block returns to idle.
- R10: `busy` is high from the cycle after an accepted request through the cycle of `done` or `err`. A request, or a changed mode or frequency code, seen while `busy` is high (including the `done` cycle) has no effect.
- R11: After reset all three control registers are zero and `busy`, `done`, `err` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, sampled while idle |
| mode | input | 4 | Timing-mode index |
| freq_code | input | 2 | Bus clock code |
| otap_sel | input | 4 | Output tap select |
| itap_sel | input | 5 | Input tap value |
| trim | input | 4 | DLL charge-pump trim |
| drive | input | 3 | DLL drive strength code |
| strobe_sel | input | 8 | Strobe select for HS400 |
| clkbuf_sel | input | 3 | Clock buffer select |
| poll_limit | input | TMO_W | Maximum DLL-ready wait in cycles |
| dll_ready | input | 1 | DLL lock status from the PHY |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle DLL timeout pulse |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | Register index written |
| wr_mask | output | 32 | Bits affected by the write |
| wr_data | output | 32 | Write data, zero outside the mask |
| ctl_dll | output | 32 | Register 0 contents |
| ctl_tap | output | 32 | Register 1 contents |
| ctl_mode | output | 32 | Register 2 contents |

## Verification
Two events can fall in the same wait cycle: the arrival of DLL ready and the expiry of the poll limit. The bench's PHY stub raises ready exactly three cycles after the enable bit appears. It then sets the limit to four, where ready lands in the final permitted cycle and must win, and to three, where the limit must expire one cycle earlier with an error and no clock-buffer write. A second collision, a request during the `done` cycle, is provoked by holding the request high, with a different mode, from the cycle after acceptance through the done cycle. The write trace must match the original mode, and the block must be idle afterwards.

// File: rtl/phy_seq_pkg.sv
// Package: shared state type, register indices and path decision for the
// PHY clock-mode sequencer. Assumes a 32-bit register file of three entries.
package phy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DLLOFF, ST_OTAP, ST_CHOFF, ST_FREQ, ST_TRIM, ST_DLLON,
        ST_POLL, ST_CHON, ST_ITAP, ST_CBUF, ST_DONE, ST_FAIL
    } seq_state_t;

    localparam int REG_W  = 32;
    localparam int NREGS  = 3;
    localparam int RADR_W = 2;

    localparam logic [RADR_W-1:0] RA_DLL  = 2'd0;
    localparam logic [RADR_W-1:0] RA_TAP  = 2'd1;
    localparam logic [RADR_W-1:0] RA_MODE = 2'd2;

    localparam logic [3:0] MODE_SDR25 = 4'd4;
    localparam logic [3:0] MODE_HS400 = 4'd10;
    localparam logic [1:0] FC_200     = 2'd0;
    localparam logic [1:0] FC_100     = 2'd1;
    localparam logic [1:0] FC_SLOW    = 2'd3;

    // Locked-DLL operation only for fast modes at a clock of 50 MHz or more
    function automatic logic use_dll(logic [3:0] m, logic [1:0] f);
        return (m > MODE_SDR25) && (f != FC_SLOW);
    endfunction

endpackage

// File: rtl/phy_seq_regs.sv
// Masked-write PHY control register file. One write per cycle; bits outside
// the mask keep their value. Assumes write data is zero outside the mask.
module phy_seq_regs #(
    parameter int W  = 32,
    parameter int N  = 3,
    parameter int AW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   data,
    output logic [N*W-1:0] q
);
    for (genvar k = 0; k < N; k++) begin : g_reg
        logic [W-1:0] r;
        // Update one register with the masked write data
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (we && addr == AW'(k))
                r <= (r & ~mask) | (data & mask);
        end
        assign q[k*W +: W] = r;
    end
endmodule

// File: rtl/phy_seq_fsm.sv
// Control FSM: accepts a request when idle, latches mode and clock code,
// walks the fixed write order for the chosen path and times the DLL wait.
// Assumes poll_limit stays stable while busy.
module phy_seq_fsm
    import phy_seq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [3:0]       mode,
    input  logic [1:0]       freq_code,
    input  logic [TMO_W-1:0] poll_limit,
    input  logic             dll_ready,
    output seq_state_t       st,
    output logic [3:0]       cur_mode,
    output logic [1:0]       cur_fc,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    logic [TMO_W-1:0] cnt;
    logic             dll_path;

    assign dll_path = use_dll(cur_mode, cur_fc);

    // Advance through the write order and count DLL wait cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_mode <= '0;
            cur_fc   <= '0;
            cnt      <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req) begin
                    st       <= ST_DLLOFF;
                    cur_mode <= mode;
                    cur_fc   <= freq_code;
                end
                ST_DLLOFF: st <= ST_OTAP;
                ST_OTAP:   st <= dll_path ? ST_CHOFF : ST_CHON;
                ST_CHOFF:  st <= ST_FREQ;
                ST_FREQ:   st <= ST_TRIM;
                ST_TRIM:   st <= ST_DLLON;
                ST_DLLON: begin
                    st  <= ST_POLL;
                    cnt <= '0;
                end
                ST_POLL: begin
                    if (dll_ready)                st  <= ST_CBUF;
                    else if (cnt + ONE >= poll_limit) st <= ST_FAIL;
                    else                          cnt <= cnt + ONE;
                end
                ST_CHON:  st <= ST_ITAP;
                ST_ITAP:  st <= ST_CBUF;
                ST_CBUF:  st <= ST_DONE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_DONE);
    assign err  = (st == ST_FAIL);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !err |=> busy);
    // R9
    err_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(st == ST_POLL && !dll_ready));
    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_POLL |-> (cnt < poll_limit) || (poll_limit == '0));
endmodule

// File: rtl/phy_seq_wgen.sv
// Write encoder: turns the FSM state and latched request into one masked
// register write. Purely combinational; data is zero outside the mask.
module phy_seq_wgen
    import phy_seq_pkg::*;
#(
    parameter bit FREQ_2BIT = 1'b1,
    parameter bit STRB_4BIT = 1'b1
) (
    input  seq_state_t        st,
    input  logic [3:0]        cur_mode,
    input  logic [1:0]        cur_fc,
    input  logic [3:0]        otap_sel,
    input  logic [4:0]        itap_sel,
    input  logic [3:0]        trim,
    input  logic [2:0]        drive,
    input  logic [7:0]        strobe_sel,
    input  logic [2:0]        clkbuf_sel,
    output logic              wr_en,
    output logic [RADR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_mask,
    output logic [REG_W-1:0]  wr_data
);
    localparam logic [REG_W-1:0] STRB_MASK = STRB_4BIT ? 32'h0F00_0000 : 32'hFF00_0000;

    logic otap_en;
    assign otap_en = (cur_mode > MODE_SDR25);

    // Encode the write belonging to the current step
    always_comb begin
        wr_en   = 1'b1;
        wr_addr = RA_DLL;
        wr_mask = '0;
        wr_data = '0;
        case (st)
            ST_DLLOFF: begin wr_addr = RA_DLL; wr_mask = 32'h1; end
            ST_OTAP: begin
                wr_addr = RA_TAP;
                wr_mask = 32'h1F;
                wr_data = {27'b0, otap_en, otap_sel};
                if (cur_mode == MODE_HS400) begin
                    wr_mask = wr_mask | STRB_MASK;
                    wr_data = wr_data | ({strobe_sel, 24'b0} & STRB_MASK);
                end
            end
            ST_CHOFF: begin wr_addr = RA_MODE; wr_mask = 32'h30; end
            ST_FREQ: begin
                wr_addr = RA_MODE;
                if (FREQ_2BIT) begin
                    wr_mask = 32'h300;
                    wr_data = (cur_fc == FC_200) ? 32'h0 :
                              (cur_fc == FC_100) ? 32'h200 : 32'h100;
                end else begin
                    wr_mask = 32'h700;
                    wr_data = (cur_fc == FC_200) ? 32'h0 : 32'h400;
                end
            end
            ST_TRIM: begin
                wr_addr = RA_DLL;
                wr_mask = 32'h7F0;
                wr_data = {21'b0, drive, trim, 4'b0};
            end
            ST_DLLON: begin wr_addr = RA_DLL; wr_mask = 32'h1; wr_data = 32'h1; end
            ST_CHON:  begin wr_addr = RA_MODE; wr_mask = 32'h30; wr_data = 32'h30; end
            ST_ITAP: begin
                wr_addr = RA_TAP;
                wr_mask = 32'h1F00;
                wr_data = {19'b0, itap_sel, 8'b0};
            end
            ST_CBUF: begin
                wr_addr = RA_MODE;
                wr_mask = 32'h7;
                wr_data = {29'b0, clkbuf_sel};
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_clkcfg_seq.sv
// Top: PHY clock-mode configuration sequencer. Joins the FSM, the write
// encoder and the control register file. Assumes configuration inputs are
// held stable from request until done or err.
module phy_clkcfg_seq
    import phy_seq_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter bit FREQ_2BIT = 1'b1,
    parameter bit STRB_4BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [3:0]       mode,
    input  logic [1:0]       freq_code,
    input  logic [3:0]       otap_sel,
    input  logic [4:0]       itap_sel,
    input  logic [3:0]       trim,
    input  logic [2:0]       drive,
    input  logic [7:0]       strobe_sel,
    input  logic [2:0]       clkbuf_sel,
    input  logic [TMO_W-1:0] poll_limit,
    input  logic             dll_ready,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             wr_en,
    output logic [1:0]       wr_addr,
    output logic [31:0]      wr_mask,
    output logic [31:0]      wr_data,
    output logic [31:0]      ctl_dll,
    output logic [31:0]      ctl_tap,
    output logic [31:0]      ctl_mode
);
    seq_state_t             st;
    logic [3:0]             cur_mode;
    logic [1:0]             cur_fc;
    logic [NREGS*REG_W-1:0] regs_q;

    phy_seq_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .freq_code(freq_code),
        .poll_limit(poll_limit), .dll_ready(dll_ready), .st(st),
        .cur_mode(cur_mode), .cur_fc(cur_fc), .busy(busy), .done(done), .err(err)
    );

    phy_seq_wgen #(.FREQ_2BIT(FREQ_2BIT), .STRB_4BIT(STRB_4BIT)) u_wgen (
        .st(st), .cur_mode(cur_mode), .cur_fc(cur_fc), .otap_sel(otap_sel),
        .itap_sel(itap_sel), .trim(trim), .drive(drive), .strobe_sel(strobe_sel),
        .clkbuf_sel(clkbuf_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    phy_seq_regs #(.W(REG_W), .N(NREGS), .AW(RADR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(wr_addr),
        .mask(wr_mask), .data(wr_data), .q(regs_q)
    );

    assign ctl_dll  = regs_q[0*REG_W +: REG_W];
    assign ctl_tap  = regs_q[1*REG_W +: REG_W];
    assign ctl_mode = regs_q[2*REG_W +: REG_W];

    // R1
    tap_write_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == RA_TAP |-> !ctl_dll[0]);
    // R8
    done_after_cbuf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en && wr_addr == RA_MODE && wr_mask == 32'h7));
    // R6
    chain_keeps_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == RA_MODE && wr_mask == 32'h30 && wr_data == 32'h30 |-> !ctl_dll[0]);
endmodule

// File: tb/sim_phy_clkcfg_seq.sv
module sim_phy_clkcfg_seq;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [3:0] mode = '0;
    logic [1:0] fcode = '0;
    logic [3:0] otap = '0;
    logic [4:0] itap = '0;
    logic [3:0] trim = '0;
    logic [2:0] drv = '0;
    logic [7:0] strb = '0;
    logic [2:0] cbuf = '0;
    logic [TW-1:0] lim = 16'd20;

    logic        busy [2], done [2], err [2], wen [2];
    logic [1:0]  wa [2];
    logic [31:0] wm [2], wd [2], c0 [2], c1 [2], c2 [2];
    logic [2:0]  pipe [2];
    logic        rdy [2];

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    phy_clkcfg_seq #(.TMO_W(TW), .FREQ_2BIT(1'b1), .STRB_4BIT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .freq_code(fcode),
        .otap_sel(otap), .itap_sel(itap), .trim(trim), .drive(drv), .strobe_sel(strb),
        .clkbuf_sel(cbuf), .poll_limit(lim), .dll_ready(rdy[0]), .busy(busy[0]),
        .done(done[0]), .err(err[0]), .wr_en(wen[0]), .wr_addr(wa[0]), .wr_mask(wm[0]),
        .wr_data(wd[0]), .ctl_dll(c0[0]), .ctl_tap(c1[0]), .ctl_mode(c2[0]));

    phy_clkcfg_seq #(.TMO_W(TW), .FREQ_2BIT(1'b0), .STRB_4BIT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .freq_code(fcode),
        .otap_sel(otap), .itap_sel(itap), .trim(trim), .drive(drv), .strobe_sel(strb),
        .clkbuf_sel(cbuf), .poll_limit(lim), .dll_ready(rdy[1]), .busy(busy[1]),
        .done(done[1]), .err(err[1]), .wr_en(wen[1]), .wr_addr(wa[1]), .wr_mask(wm[1]),
        .wr_data(wd[1]), .ctl_dll(c0[1]), .ctl_tap(c1[1]), .ctl_mode(c2[1]));

    // PHY stub: ready follows the DLL enable bit three cycles later
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= {pipe[i][1:0], (i == 0) ? c0[0][0] : c0[1][0]};
        end
    end
    assign rdy[0] = pipe[0][2];
    assign rdy[1] = pipe[1][2];

    // Write trace recorder
    logic [1:0]  ra [2][16];
    logic [31:0] rm [2][16], rd [2][16];
    int rn [2];
    bit rec_on = 0;
    always @(negedge clk) begin
        if (rec_on) begin
            for (int i = 0; i < 2; i++) begin
                if (wen[i] && rn[i] < 16) begin
                    ra[i][rn[i]] = wa[i]; rm[i][rn[i]] = wm[i]; rd[i][rn[i]] = wd[i];
                    rn[i] = rn[i] + 1;
                end
            end
        end
    end

    // Expected trace and register model
    logic [1:0]  ea [16];
    logic [31:0] em [16], ed [16];
    int en;
    logic [31:0] mreg [2][3];

    task automatic chk(input string tag, input int inst, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s inst%0d mode%0d fc%0d: got %h expected %h", tag, inst, mode, fcode, got, exp);
        end
    endtask

    task automatic add(input logic [1:0] a, input logic [31:0] m, input logic [31:0] d);
        ea[en] = a; em[en] = m; ed[en] = d; en++;
    endtask

    task automatic build(input int inst, input int m, input int fc, input bit fail);
        bit f2, s4, dll;
        logic [31:0] sm, mk, dt;
        f2 = (inst == 0); s4 = (inst == 0);
        dll = (m > 4) && (fc != 3);
        en = 0;
        add(2'd0, 32'h1, 32'h0);
        mk = 32'h1F; dt = {27'b0, (m > 4), otap};
        if (m == 10) begin
            sm = s4 ? 32'h0F00_0000 : 32'hFF00_0000;
            mk = mk | sm; dt = dt | ({strb, 24'b0} & sm);
        end
        add(2'd1, mk, dt);
        if (dll) begin
            add(2'd2, 32'h30, 32'h0);
            if (f2) add(2'd2, 32'h300, (fc == 0) ? 32'h0 : (fc == 1) ? 32'h200 : 32'h100);
            else    add(2'd2, 32'h700, (fc == 0) ? 32'h0 : 32'h400);
            add(2'd0, 32'h7F0, {21'b0, drv, trim, 4'b0});
            add(2'd0, 32'h1, 32'h1);
        end else begin
            add(2'd2, 32'h30, 32'h30);
            add(2'd1, 32'h1F00, {19'b0, itap, 8'b0});
        end
        if (!fail) add(2'd2, 32'h7, {29'b0, cbuf});
    endtask

    task automatic judge(input int inst, input int m, input int fc, input bit fail,
                         input bit gd, input bit ge);
        bit dll;
        string tag;
        dll = (m > 4) && (fc != 3);
        build(inst, m, fc, fail);
        chk("R3 write count", inst, 64'(rn[inst]), 64'(en));
        for (int i = 0; i < en && i < rn[inst]; i++) begin
            if (i == 0) tag = "R1";
            else if (i == 1) tag = (m == 10) ? "R7" : "R2";
            else if (i == en - 1 && !fail) tag = "R8";
            else if (dll) tag = (i == 3) ? "R5" : "R4";
            else tag = "R6";
            chk(tag, inst, {30'b0, ra[inst][i], rm[inst][i]}, {30'b0, ea[i], em[i]});
            chk(tag, inst, 64'(rd[inst][i]), 64'(ed[i]));
        end
        for (int i = 0; i < en; i++)
            mreg[inst][ea[i]] = (mreg[inst][ea[i]] & ~em[i]) | (ed[i] & em[i]);
        chk("R9 done/err", inst, {62'b0, gd, ge}, {62'b0, !fail, fail});
        chk("R8 registers", inst, {c0[inst], c1[inst]}, {mreg[inst][0], mreg[inst][1]});
        chk("R8 registers", inst, 64'(c2[inst]), 64'(mreg[inst][2]));
    endtask

    task automatic run(input int m, input int fc, input int l, input bit hold, input bit fail);
        bit gd [2], ge [2];
        int n;
        otap = 4'((m * 3 + fc) & 15);
        itap = 5'((m * 5 + fc * 7) & 31);
        trim = 4'((m + 2 * fc) & 15);
        drv  = 3'((m + fc) & 7);
        strb = 8'h5A ^ 8'(m * 17 + fc);
        cbuf = 3'((m + fc + 1) & 7);
        lim  = TW'(l);
        rn[0] = 0; rn[1] = 0;
        rec_on = 1;
        @(negedge clk);
        req = 1'b1; mode = 4'(m); fcode = 2'(fc);
        @(negedge clk);
        chk("R10 busy after request", 0, 64'(busy[0]), 64'd1);
        if (hold) begin mode = 4'((m + 3) % 11); fcode = 2'((fc + 1) & 3); end
        else req = 1'b0;
        n = 0;
        while (!(done[0] || err[0]) && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) chk("R9 watchdog", 0, 64'd0, 64'd1);
        gd[0] = done[0]; ge[0] = err[0]; gd[1] = done[1]; ge[1] = err[1];
        @(negedge clk);
        if (hold) begin
            req = 1'b0;
            chk("R10 ignored during done", 0, 64'(busy[0]), 64'd0);
            @(negedge clk);
            chk("R10 ignored during done", 0, 64'(busy[0]), 64'd0);
        end
        rec_on = 0;
        mode = 4'(m); fcode = 2'(fc);
        for (int i = 0; i < 2; i++) judge(i, m, fc, fail, gd[i], ge[i]);
    endtask

    initial begin
        #1ms;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) for (int j = 0; j < 3; j++) mreg[i][j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int i = 0; i < 2; i++) begin
            chk("R11 reset regs", i, {c0[i], c1[i]}, 64'd0);
            chk("R11 reset regs", i, 64'(c2[i]), 64'd0);
            chk("R11 reset flags", i, {60'b0, busy[i], done[i], err[i], wen[i]}, 64'd0);
        end
        // Sweep every mode against every clock code
        for (int m = 0; m <= 10; m++)
            for (int fc = 0; fc < 4; fc++)
                run(m, fc, 20, 1'b0, 1'b0);
        // R9 ready in the last permitted cycle, then one cycle too late
        run(9, 0, 4, 1'b0, 1'b0);
        run(9, 0, 3, 1'b0, 1'b1);
        run(10, 1, 3, 1'b0, 1'b1);
        // R10 request held high with other values through the done cycle
        run(6, 1, 20, 1'b1, 1'b0);
        run(2, 0, 20, 1'b1, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule